// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the destination address of an incoming Ethernet frame as a serial bit stream and decides whether the frame is kept or dropped. Bits arrive in wire order: six bytes, each sent least significant bit first. The first bit on the wire gives the address type. A 0 marks a unicast address. A 1 marks a group address, and a group address of all ones is broadcast.

A unicast address is kept only when it equals the programmed node address exactly. A group address other than broadcast is hashed with a serial CRC-32 over the 48 address bits. The top six CRC bits select one bit of a 64-bit hash filter, and that bit keeps or drops the frame. Broadcast is recognised on its own and has its own disable control. Promiscuous mode keeps every frame.

A MAC receive path pulses `frameStart` before each destination address and then presents address bits with `bitValid`. One clock after the 48th bit, the block pulses `decisionValid` for one cycle. The verdict and the match-type flags are valid in that same cycle.

Top module: `addr_filter_top`

## Requirements
- R1: After reset, `decisionValid`, `accept`, `unicastHit`, `multicastHit` and `broadcastSeen` are all 0.
- R2: The n-th address bit presented with `bitValid` after `frameStart` (n = 0..47) is compared with `nodeAddr[n]`. So the first wire byte maps to `nodeAddr[7:0]` and the sixth byte maps to `nodeAddr[47:40]`. A unicast address (first bit 0) equal to `nodeAddr` gives `accept`=1 and `unicastHit`=1. Any difference gives `accept`=0 unless another rule accepts the frame.
- R3: For a group address that is not broadcast, a CRC-32 is computed serially over the 48 bits in wire order. It uses polynomial 0x04C11DB7 and is preset to all ones. Each step is: feedback = crc[31] XOR bit, then crc = (crc << 1) XOR (feedback ? poly : 0). The index `crc[31:26]` selects `hashFilter[index]`. A selected 1 gives `accept`=1 and `multicastHit`=1, and a selected 0 rejects the frame.
- R4: When `hashFilter` is all zeros and promiscuous mode is off, every group address other than broadcast is rejected.
- R5: An all-ones address sets `broadcastSeen`=1 and is never a hash hit (`multicastHit`=0). It is accepted when `bcastDisable`=0 and rejected when `bcastDisable`=1, whatever the hash filter holds.
- R6: With `promiscEn`=1, every completed address gives `accept`=1. The match-type flags still report the address type.
- R7: `decisionValid` rises exactly one clock after the cycle carrying the 48th address bit, and it stays high for one cycle. Further bits before the next `frameStart` produce no further decision.
- R8: `frameStart` clears the bit count and the CRC state. A partly received address is dropped, and the next 48 bits form a fresh address. Cycles with `bitValid`=0 are skipped without counting.
- R9: `nodeAddr`, `hashFilter`, `promiscEn` and `bcastDisable` are sampled only in the `frameStart` cycle. Changing them during the address does not change that frame's decision.
- R10: Outside the `decisionValid` cycle, `accept`, `unicastHit`, `multicastHit` and `broadcastSeen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse before a new destination address; samples configuration |
| bitValid | input | 1 | `bitIn` carries an address bit this cycle |
| bitIn | input | 1 | Serial address bit, wire order |
| nodeAddr | input | 48 | Station unicast address (bit 0 = first wire bit) |
| hashFilter | input | 64 | Group address hash filter |
| promiscEn | input | 1 | Accept all frames |
| bcastDisable | input | 1 | Reject broadcast frames |
| decisionValid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame kept |
| unicastHit | output | 1 | Unicast address matched node address |
| multicastHit | output | 1 | Group address hit in hash filter |
| broadcastSeen | output | 1 | Address was all ones |

## Verification
The hardest case to reach from the ports is a hash lookup that hits exactly one filter bit. Random group addresses land on an arbitrary index, so a full or empty filter cannot tell a correct index from a wrong one. For this case the bench runs its own serial CRC model over a chosen address, sets only the computed filter bit, and then sets every filter bit except that one. A shifted or reversed index then shows up as a wrong verdict. The bench also reaches a restart in the middle of an address and a configuration change during an address by driving `frameStart` and the configuration inputs between bits.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  typedef struct packed {
    logic clear;   // new frame: reset count/CRC, take config snapshot
    logic shift;   // consume one address bit
    logic decide;  // this bit is the last address bit
  } filtStrobes_t;
endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         bitValid,
  output filtStrobes_t strobes
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_W);

  logic [CNT_W-1:0] bitCount;
  logic armed;

  always_comb begin
    strobes.clear  = frameStart;
    strobes.shift  = armed && bitValid && !frameStart && (bitCount < FULL_CNT);
    strobes.decide = strobes.shift && (bitCount == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
      armed    <= 1'b0;
    end else if (frameStart) begin
      bitCount <= '0;
      armed    <= 1'b1;
    end else if (strobes.shift) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  // R8: counter never runs past the address length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= FULL_CNT);

  // R7: a decision is requested at most once in a row
  a_r7_single_decide: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decide |=> !strobes.decide);
endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W = 6,
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  filtStrobes_t          strobes,
  input  logic                  bitIn,
  input  logic [ADDR_W-1:0]     nodeAddr,
  input  logic [(1<<IDX_W)-1:0] hashFilter,
  input  logic                  promiscEn,
  input  logic                  bcastDisable,
  output logic                  decisionValid,
  output logic                  accept,
  output logic                  unicastHit,
  output logic                  multicastHit,
  output logic                  broadcastSeen
);
  localparam int FILT_W = 1 << IDX_W;

  logic [ADDR_W-1:0] nodeSnap;
  logic [FILT_W-1:0] filtSnap;
  logic              promSnap;
  logic              bcDisSnap;
  logic [ADDR_W-1:0] addrReg;
  logic [CRC_W-1:0]  crcReg;

  logic [ADDR_W-1:0] addrNext;
  logic [CRC_W-1:0]  crcNext;
  logic              crcFb;
  logic [IDX_W-1:0]  hashIdx;
  logic              isGroup, isBcast, ucMatch, mcMatch, bcOk, keepFrame;

  always_comb begin
    addrNext  = {bitIn, addrReg[ADDR_W-1:1]};
    crcFb     = crcReg[CRC_W-1] ^ bitIn;
    crcNext   = {crcReg[CRC_W-2:0], 1'b0} ^ (crcFb ? CRC_POLY : '0);
    hashIdx   = crcNext[CRC_W-1 -: IDX_W];
    isGroup   = addrNext[0];
    isBcast   = &addrNext;
    ucMatch   = !isGroup && (addrNext == nodeSnap);
    mcMatch   = isGroup && !isBcast && filtSnap[hashIdx];
    bcOk      = isBcast && !bcDisSnap;
    keepFrame = promSnap || ucMatch || mcMatch || bcOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nodeSnap  <= '0;
      filtSnap  <= '0;
      promSnap  <= 1'b0;
      bcDisSnap <= 1'b0;
      addrReg   <= '0;
      crcReg    <= '1;
    end else if (strobes.clear) begin
      nodeSnap  <= nodeAddr;
      filtSnap  <= hashFilter;
      promSnap  <= promiscEn;
      bcDisSnap <= bcastDisable;
      addrReg   <= '0;
      crcReg    <= '1;
    end else if (strobes.shift) begin
      addrReg <= addrNext;
      crcReg  <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
      unicastHit    <= 1'b0;
      multicastHit  <= 1'b0;
      broadcastSeen <= 1'b0;
    end else begin
      decisionValid <= strobes.decide;
      accept        <= strobes.decide && keepFrame;
      unicastHit    <= strobes.decide && ucMatch;
      multicastHit  <= strobes.decide && mcMatch;
      broadcastSeen <= strobes.decide && isBcast;
    end
  end

  // R5: broadcast never counts as a hash hit
  a_r5_bcast_not_hash: assert property (@(posedge clk) disable iff (!rstN)
    broadcastSeen |-> !multicastHit);

  // R6: promiscuous snapshot forces acceptance
  a_r6_promisc_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && promSnap) |-> accept);

  // R2: a unicast hit is always an accept
  a_r2_unicast_keeps: assert property (@(posedge clk) disable iff (!rstN)
    unicastHit |-> accept);

  // R10: flags are quiet outside the strobe
  a_r10_quiet_flags: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> !(accept || unicastHit || multicastHit || broadcastSeen));

  // R7: strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);
endmodule

// File: rtl/addr_filter_top.sv
module addr_filter_top
  import addr_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W = 6,
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStart,
  input  logic                  bitValid,
  input  logic                  bitIn,
  input  logic [ADDR_W-1:0]     nodeAddr,
  input  logic [(1<<IDX_W)-1:0] hashFilter,
  input  logic                  promiscEn,
  input  logic                  bcastDisable,
  output logic                  decisionValid,
  output logic                  accept,
  output logic                  unicastHit,
  output logic                  multicastHit,
  output logic                  broadcastSeen
);
  filtStrobes_t strobes;

  addr_filter_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .bitValid(bitValid), .strobes(strobes)
  );

  addr_filter_dp #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .nodeAddr(nodeAddr), .hashFilter(hashFilter), .promiscEn(promiscEn),
    .bcastDisable(bcastDisable), .decisionValid(decisionValid),
    .accept(accept), .unicastHit(unicastHit), .multicastHit(multicastHit),
    .broadcastSeen(broadcastSeen)
  );
endmodule

// File: tb/addr_filter_tb.sv
module addr_filter_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, bitValid = 1'b0, bitIn = 1'b0;
  logic [47:0] nodeAddr = '0;
  logic [63:0] hashFilter = '0;
  logic promiscEn = 1'b0, bcastDisable = 1'b0;
  logic decisionValid, accept, unicastHit, multicastHit, broadcastSeen;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addr_filter_top dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .nodeAddr(nodeAddr), .hashFilter(hashFilter),
    .promiscEn(promiscEn), .bcastDisable(bcastDisable),
    .decisionValid(decisionValid), .accept(accept), .unicastHit(unicastHit),
    .multicastHit(multicastHit), .broadcastSeen(broadcastSeen)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic [47:0] node;
    logic [63:0] filt;
    logic prom;
    logic bcDis;
    logic [3:0] exp;  // {accept, unicastHit, multicastHit, broadcastSeen}
  } vec_t;

  localparam logic [47:0] NODE_A = 48'h1234_5678_9ABC;
  localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;
  localparam vec_t VECS [8] = '{
    '{NODE_A,               NODE_A, 64'h0, 1'b0, 1'b0, 4'b1100}, // R2 match
    '{48'h1234_5678_9ABE,   NODE_A, 64'h0, 1'b0, 1'b0, 4'b0000}, // R2 mismatch
    '{48'h0000_0000_0001,   NODE_A, '1,    1'b0, 1'b0, 4'b1010}, // R3 full filter
    '{48'h0000_0000_0001,   NODE_A, 64'h0, 1'b0, 1'b0, 4'b0000}, // R4 empty filter
    '{BCAST,                NODE_A, 64'h0, 1'b0, 1'b0, 4'b1001}, // R5 bcast on
    '{BCAST,                NODE_A, '1,    1'b0, 1'b1, 4'b0001}, // R5 bcast off
    '{48'h1234_5678_9ABE,   NODE_A, 64'h0, 1'b1, 1'b0, 4'b1000}, // R6 promisc
    '{BCAST,                NODE_A, 64'h0, 1'b1, 1'b1, 4'b1001}  // R6 promisc bcast
  };

  function automatic logic [5:0] hashOf(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    chkCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {decisionValid, accept, unicastHit, multicastHit, broadcastSeen};
  endfunction

  task automatic startFrame();
    frameStart = 1'b1; bitValid = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // Send bits lo..hi-1; returns at negedge after the last bit's clock edge
  task automatic sendBits(input logic [47:0] a, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      bitValid = 1'b1; bitIn = a[i];
      @(negedge clk);
    end
    bitValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCount++; chkCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outs(), 5'b0);

    foreach (VECS[k]) begin
      nodeAddr = VECS[k].node; hashFilter = VECS[k].filt;
      promiscEn = VECS[k].prom; bcastDisable = VECS[k].bcDis;
      startFrame();
      sendBits(VECS[k].addr, 0, 48);
      check($sformatf("R%0d vec%0d", (k < 2) ? 2 : (k < 4) ? 3 + (k-2) : (k < 6) ? 5 : 6, k),
            outs(), {1'b1, VECS[k].exp});
      @(negedge clk);
      check("R10", outs(), 5'b0);
    end
    promiscEn = 1'b0; bcastDisable = 1'b0;

    // R3: single filter bit at computed index
    begin
      logic [47:0] ga = 48'h5E00_A1B2_C301;
      logic [5:0] idx = hashOf(ga);
      hashFilter = 64'h1 << idx;
      startFrame(); sendBits(ga, 0, 48);
      check("R3 single bit hit", outs(), 5'b11010);
      hashFilter = ~(64'h1 << idx);
      startFrame(); sendBits(ga, 0, 48);
      check("R3 single bit miss", outs(), 5'b10000);
    end

    // R9: config change mid-address has no effect
    nodeAddr = NODE_A; hashFilter = '0;
    startFrame(); sendBits(NODE_A, 0, 20);
    nodeAddr = 48'h0; promiscEn = 1'b1;
    sendBits(NODE_A, 20, 48);
    check("R9 snapshot unicast", outs(), 5'b11100);
    promiscEn = 1'b0;
    nodeAddr = 48'h0;
    startFrame(); sendBits(NODE_A, 0, 10);
    nodeAddr = NODE_A;
    sendBits(NODE_A, 10, 48);
    check("R9 snapshot mismatch", outs(), 5'b10000);

    // R8: restart mid-address, plus gaps in bitValid
    nodeAddr = NODE_A;
    startFrame(); sendBits(48'hFFFF_FFFF_FFFF, 0, 30);
    startFrame();
    for (int i = 0; i < 48; i++) begin
      bitValid = 1'b1; bitIn = NODE_A[i];
      @(negedge clk);
      if (i < 47) begin
        bitValid = 1'b0; bitIn = ~NODE_A[i];
        @(negedge clk);
        if (decisionValid) check("R8 early decision", outs(), 5'b0);
      end
    end
    bitValid = 1'b0;
    check("R8 restart and gaps", outs(), 5'b11100);

    // R7: extra bits after 48 produce no decision
    startFrame(); sendBits(NODE_A, 0, 47);
    check("R7 no decision before last bit", outs(), 5'b0);
    sendBits(NODE_A, 47, 48);
    check("R7 decision timing", outs(), 5'b11100);
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
        bitValid = 1'b1; bitIn = 1'b0;
        @(negedge clk);
        seen |= decisionValid;
      end
      bitValid = 1'b0;
      check("R7 no extra decision", {4'b0, seen}, 5'b0);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule